// File: doc/BRIEF.md
# Floppy Controller Interface Decoder

This block sits between the I/O bus and an external floppy disk controller. It generates the controller's chip select for I/O reads and writes that fall in an 8-byte window. A configuration input chooses the primary window (03F0h–03F7h) or the secondary window (0370h–0377h).

On a read of the window's top address it drives the inverted disk-change line onto data bit 7 and enables that one bit's output driver. The other data bits stay with the controller.

During reset the block samples the disk-change line to find out whether a controller is fitted. If that line is low when reset ends, all floppy support stays off until the next reset. The block also lights the disk activity lamp whenever either of two system-control bits is set. Those two bits are bit 6 and bit 7 of the register at port 92h.

Top module: `fdc_if_decode`

## Requirements
- R1: With `win_sec` = 0, the controller fitted and reset released, `fdc_sel` is 1 exactly when `io_rd` or `io_wr` is 1 and `io_addr` lies in 03F0h–03F7h.
- R2: With `win_sec` = 1, the window is 0370h–0377h instead, and addresses in 03F0h–03F7h no longer select.
- R3: `fdc_sel` is 0 whenever neither strobe is active or the address lies outside the chosen window, including the addresses just below and just above it.
- R4: On a read (`io_rd` = 1) of the window's top address (03F7h for the primary window, 0377h for the secondary), `sd7_oe` is 1 and `sd7_out` equals the inverse of `disk_change_n`.
- R5: `sd7_oe` is 0 on writes, when no read is active, and on every other address, including the other seven addresses of the window.
- R6: The presence flag takes the level of `disk_change_n` at the last rising clock edge with `rst_n` low. It keeps that value after reset, whatever `disk_change_n` does later.
- R7: If the presence flag is 0 (no controller), `fdc_sel` and `sd7_oe` stay 0 for every access.
- R8: `disk_light` is 1 when either bit of `light_req` is 1. Bit 0 carries system-control bit 6 and bit 1 carries bit 7. This holds whether or not a controller is present.
- R9: While `rst_n` is low, `fdc_sel` and `sd7_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset; presence is sampled while low |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| win_sec | input | 1 | 0: primary window, 1: secondary window |
| disk_change_n | input | 1 | Disk-change line from the drive interface, active low |
| light_req | input | 2 | System-control bits 6 (bit 0) and 7 (bit 1) |
| fdc_sel | output | 1 | Controller chip select, active high |
| sd7_out | output | 1 | Value for data bit 7 during a top-address read |
| sd7_oe | output | 1 | Output enable for data bit 7 |
| disk_light | output | 1 | Disk activity lamp, active high |

## Verification
Some properties are checked on every cycle outside reset. Chip select never appears without a fitted controller. The bit-7 driver turns on only during reads and only together with chip select. The presence flag never changes once reset has ended.

Other behaviour is shown only by the bench's scenarios against its behavioural model. These cover the exact window edges for both window settings and the inverted bit-7 value. They also cover presence following the last edge of reset rather than an earlier one, and the lamp responding to each request bit on its own.

// File: rtl/fdc_pkg.sv
// fdc_pkg: shared types and helpers for the floppy interface decoder.
// Assumes windows are aligned to their own size (base low bits are zero).
package fdc_pkg;

    typedef enum logic {
        WIN_PRIMARY   = 1'b0,
        WIN_SECONDARY = 1'b1
    } fdc_win_e;

endpackage

// File: rtl/fdc_win_decode.sv
// fdc_win_decode: compares an I/O address against one of two aligned
// windows of 2**WIN_W bytes and flags a hit and a hit on the top address.
// Assumes PRI_BASE and SEC_BASE have their low WIN_W bits clear.
module fdc_win_decode #(
    parameter int             ADDR_W   = 16,
    parameter int             WIN_W    = 3,
    parameter logic [ADDR_W-1:0] PRI_BASE = 16'h03F0,
    parameter logic [ADDR_W-1:0] SEC_BASE = 16'h0370
) (
    input  logic [ADDR_W-1:0] addr,
    input  fdc_pkg::fdc_win_e win,
    output logic              hit,
    output logic              hit_top
);
    localparam int TAG_W = ADDR_W - WIN_W;

    logic [ADDR_W-1:0] base;

    // Pick the base of the active window.
    always_comb begin
        base = (win == fdc_pkg::WIN_SECONDARY) ? SEC_BASE : PRI_BASE;
    end

    generate
        if (WIN_W == 0) begin : g_single
            // A one-byte window: every hit is the top address.
            always_comb begin
                hit     = (addr == base);
                hit_top = hit;
            end
        end else begin : g_multi
            // Match the upper bits, then test the low bits for all ones.
            always_comb begin
                hit     = (addr[ADDR_W-1 -: TAG_W] == base[ADDR_W-1 -: TAG_W]);
                hit_top = hit && (&addr[WIN_W-1:0]);
            end
        end
    endgenerate
endmodule

// File: rtl/fdc_presence.sv
// fdc_presence: records whether a controller is fitted. While reset is
// low the flag follows the sense line on each clock edge; once reset is
// released the flag holds until the next reset. Assumes synchronous reset.
module fdc_presence (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_n,
    output logic present
);
    logic present_q;

    // Track the sense line during reset, hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) present_q <= sense_n;
    end

    assign present = present_q;

    AST_PRESENCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(present_q)) else $error("presence changed after reset"); // R6
endmodule

// File: rtl/fdc_dlight.sv
// fdc_dlight: drives the disk activity lamp when any request bit is set.
// Assumes request bits are already synchronous to the bus clock.
module fdc_dlight #(
    parameter int REQ_W = 2
) (
    input  logic [REQ_W-1:0] req,
    output logic             light
);
    // Any request turns the lamp on.
    always_comb begin
        light = |req;
    end
endmodule

// File: rtl/fdc_if_decode.sv
// fdc_if_decode: top of the floppy interface decoder. Generates the
// controller chip select, drives data bit 7 with the inverted disk-change
// line on top-address reads, gates everything on the presence flag and
// reset, and drives the disk lamp. Assumes strobes are active high and
// synchronous to clk.
module fdc_if_decode #(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_W    = 3,
    parameter logic [ADDR_W-1:0] PRI_BASE = 16'h03F0,
    parameter logic [ADDR_W-1:0] SEC_BASE = 16'h0370,
    parameter int                LIGHT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_rd,
    input  logic               io_wr,
    input  logic               win_sec,
    input  logic               disk_change_n,
    input  logic [LIGHT_W-1:0] light_req,
    output logic               fdc_sel,
    output logic               sd7_out,
    output logic               sd7_oe,
    output logic               disk_light
);
    logic              present;
    logic              hit;
    logic              hit_top;
    logic              enabled;
    fdc_pkg::fdc_win_e win;

    assign win = fdc_pkg::fdc_win_e'(win_sec);

    fdc_win_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_W    (WIN_W),
        .PRI_BASE (PRI_BASE),
        .SEC_BASE (SEC_BASE)
    ) u_win (
        .addr    (io_addr),
        .win     (win),
        .hit     (hit),
        .hit_top (hit_top)
    );

    fdc_presence u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_n (disk_change_n),
        .present (present)
    );

    fdc_dlight #(.REQ_W(LIGHT_W)) u_light (
        .req   (light_req),
        .light (disk_light)
    );

    // Support is live only out of reset with a controller fitted.
    always_comb begin
        enabled = rst_n && present;
    end

    // Chip select for any strobed access inside the window.
    always_comb begin
        fdc_sel = enabled && (io_rd || io_wr) && hit;
    end

    // Bit-7 driver: top-address reads only, value is inverted disk change.
    always_comb begin
        sd7_oe  = enabled && io_rd && hit_top;
        sd7_out = sd7_oe ? !disk_change_n : 1'b0;
    end

    AST_SEL_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        !present |-> !fdc_sel && !sd7_oe) else $error("select without controller"); // R7
    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sd7_oe |-> io_rd) else $error("bit 7 driven outside a read"); // R5
    AST_OE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sd7_oe |-> fdc_sel) else $error("bit 7 driven without select"); // R4
endmodule

// File: tb/test_fdc_if_decode.sv
module test_fdc_if_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        win_sec = 1'b0;
    logic        disk_change_n = 1'b1;
    logic [1:0]  light_req = 2'b00;
    logic        fdc_sel, sd7_out, sd7_oe, disk_light;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit m_present = 0;

    always #4 clk = ~clk;   // 125 MHz

    fdc_if_decode i_fdc_if_decode (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .win_sec(win_sec), .disk_change_n(disk_change_n), .light_req(light_req),
        .fdc_sel(fdc_sel), .sd7_out(sd7_out), .sd7_oe(sd7_oe), .disk_light(disk_light)
    );

    // Behavioural model of the presence flag (R6).
    always @(posedge clk) if (!rst_n) m_present <= disk_change_n;

    function automatic bit in_win(input logic [15:0] a, input bit sec);
        int base = sec ? 'h370 : 'h3F0;
        return (int'(a) >= base) && (int'(a) <= base + 7);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (addr %h rd %b wr %b sec %b)",
                     req, act, exp, io_addr, io_rd, io_wr, win_sec);
        end
    endtask

    // Apply inputs at the falling edge, compare every output mid-phase.
    task automatic step(input logic [15:0] a, input bit rd, input bit wr, input bit sec,
                        input bit dc_n, input logic [1:0] lr, input bit rn, input string tag);
        bit    e_sel, e_oe;
        string rs, ro;
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = wr; win_sec = sec;
        disk_change_n = dc_n; light_req = lr; rst_n = rn;
        #2;
        e_sel = rn && m_present && (rd || wr) && in_win(a, sec);
        e_oe  = rn && m_present && rd && (int'(a) == (sec ? 'h377 : 'h3F7));
        if (tag != "")        rs = tag;
        else if (!rn)         rs = "R9";
        else if (!m_present)  rs = "R7";
        else if (!e_sel)      rs = "R3";
        else if (sec)         rs = "R2";
        else                  rs = "R1";
        ro = e_oe ? "R4" : (rn ? "R5" : "R9");
        chk(rs, fdc_sel, e_sel);
        chk(ro, sd7_oe, e_oe);
        if (e_oe) chk("R4", sd7_out, !dc_n);
        chk("R8", disk_light, lr != 2'b00);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        // Reset with controller fitted; outputs quiet during reset (R9).
        for (int i = 0; i < 3; i++) step(16'h03F7, 1, 0, 0, 1, 2'b00, 0, "R9");
        step(16'h03F0, 1, 0, 0, 1, 2'b00, 1, "R6");
        // Primary window sweep, reads and writes (R1, R3, R4, R5).
        for (int a = 'h3EE; a <= 'h3F9; a++) begin
            step(16'(a), 1, 0, 0, 1, 2'b00, 1, "");
            step(16'(a), 0, 1, 0, 0, 2'b00, 1, "");
            step(16'(a), 0, 0, 0, 1, 2'b00, 1, "");
        end
        // Top-address read with both disk-change levels (R4).
        step(16'h03F7, 1, 0, 0, 0, 2'b00, 1, "");
        step(16'h03F7, 1, 0, 0, 1, 2'b00, 1, "");
        // Secondary window sweep; primary no longer selects (R2).
        for (int a = 'h36E; a <= 'h379; a++) begin
            step(16'(a), 1, 0, 1, 0, 2'b00, 1, "");
            step(16'(a), 0, 1, 1, 1, 2'b00, 1, "");
        end
        step(16'h03F3, 1, 0, 1, 1, 2'b00, 1, "R2");
        step(16'h03F7, 1, 0, 1, 1, 2'b00, 1, "R2");
        step(16'h0377, 1, 0, 1, 1, 2'b00, 1, "");
        // Lamp request bits one at a time and together (R8).
        step(16'h0000, 0, 0, 0, 1, 2'b01, 1, "");
        step(16'h0000, 0, 0, 0, 1, 2'b10, 1, "");
        step(16'h0000, 0, 0, 0, 1, 2'b11, 1, "");
        step(16'h0000, 0, 0, 0, 1, 2'b00, 1, "");
        // Reset: high early, low on the last edge -> absent (R6, R7).
        step(16'h03F2, 1, 0, 0, 1, 2'b00, 0, "R9");
        step(16'h03F2, 1, 0, 0, 1, 2'b00, 0, "R9");
        step(16'h03F2, 1, 0, 0, 0, 2'b00, 0, "R9");
        step(16'h03F2, 1, 0, 0, 1, 2'b00, 1, "R6");
        step(16'h03F7, 1, 0, 0, 1, 2'b11, 1, "R7");
        step(16'h0377, 1, 0, 1, 0, 2'b01, 1, "R7");
        step(16'h03F1, 0, 1, 0, 1, 2'b00, 1, "R7");
        // Reset: low early, high on the last edge -> present (R6).
        step(16'h03F2, 0, 0, 0, 0, 2'b00, 0, "R9");
        step(16'h03F2, 0, 0, 0, 1, 2'b00, 0, "R9");
        step(16'h03F2, 1, 0, 0, 0, 2'b00, 1, "R6");
        // Later disk-change activity leaves presence alone (R6).
        for (int i = 0; i < 4; i++) step(16'h03F7, 1, 0, 0, i[0], 2'b00, 1, "R6");
        finish_up();
    end
endmodule